// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer driven from a single 16-bit write port. Its control word can only be replaced after a two-word unlock key has been written. A different two-word key restarts the running count without touching the configuration. While armed, the block counts clock cycles; if the count reaches the selected period before a restart arrives, it raises a one-cycle timeout pulse, sets a sticky flag and begins a fresh period.

The key-sequence state machine has four states. `KS_IDLE` waits for the first word of either key. Writing 0x3333 moves it to `KS_CFG_HALF`, and writing 0xAAAA moves it to `KS_RST_HALF`. From `KS_CFG_HALF`, 0xCCCC moves it to `KS_CFG_OPEN`. In `KS_CFG_OPEN`, the next write of any value is loaded as the control word and the machine returns to idle. From `KS_RST_HALF`, 0x5555 issues a restart and returns to idle. Any other write in a half state returns the machine to idle with no side effect. Cycles without a write never move the machine.

The period is set by a one-hot field in control bits 7..1, and the arm condition is carried in bits 15 and 14. The parameter `BASE_EXP` sets the length of the shortest period; its default of 24 gives 2^24 cycles for bit 1.

Top module: `wdt_keyed`

## Requirements
- R1: Writing 0x3333 and then 0xCCCC, followed by a third write, loads that third word in full into the control register. The new value appears on `ctrl_q` in the cycle after the third write.
- R2: Loading the control value 0x0000 disarms the watchdog. No timeout pulse then occurs, however long the block runs.
- R3: Writing 0xAAAA and then 0x5555 zeroes the count. It leaves `ctrl_q` unchanged.
- R4: The watchdog is armed only when control bits 15 and 14 are both 1 and at least one bit of 7..1 is 1. Otherwise no timeout pulse occurs.
- R5: If the lowest set bit of control bits 7..1 is bit k, the period is 2^(BASE_EXP+k-1) cycles. The pulse is high in the cycle after the period-th rising edge that follows the load or the restart.
- R6: The timeout pulse lasts exactly one cycle. The count starts again from zero, so pulses repeat every period while the watchdog stays armed.
- R7: A write that breaks a key sequence in progress returns the machine to idle. It loads no control value and issues no restart.
- R8: The expired flag is set together with the timeout pulse. Only a restart clears it; a control load does not.
- R9: Restart sequences issued more often than once per period keep the timeout pulse from ever rising.
- R10: A restart whose second word is written on the same edge on which the count expires wins: no pulse occurs and the flag is not set.
- R11: After reset, `ctrl_q` is 0, the flag and the pulse are low, and the machine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 16 | Written word |
| ctrl_q | output | 16 | Current control value |
| expired_flag | output | 1 | Sticky timeout-occurred flag |
| timeout_pulse | output | 1 | One-cycle timeout indication |

## Verification
The assertions assume that every period is at least two cycles, so two timeout pulses can never fall on adjacent cycles. They also assume that a write is sampled only when `wr_en` is high, which makes a change of `ctrl_q` traceable to a write made in `KS_CFG_OPEN`. The bench runs with a small `BASE_EXP`, so the shortest period is 16 cycles and every legal period is far above that bound. The bench drives at most one write per cycle, each held for exactly one clock, and places restarts both well inside a period and on the exact edge where the count expires.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_CFG_HALF,
        KS_CFG_OPEN,
        KS_RST_HALF
    } key_state_e;

    localparam int          WORD_W     = 16;
    localparam logic [15:0] KEY_CFG_A  = 16'h3333;
    localparam logic [15:0] KEY_CFG_B  = 16'hCCCC;
    localparam logic [15:0] KEY_RST_A  = 16'hAAAA;
    localparam logic [15:0] KEY_RST_B  = 16'h5555;
    localparam int          ARM_HI_BIT = 15;
    localparam int          ARM_LO_BIT = 14;
    localparam int          SEL_LSB    = 1;
    localparam int          SEL_W      = 7;

endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output key_state_e        state_q,
    output logic              load_ctrl,
    output logic              restart
);

    key_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                KS_IDLE: begin
                    if (wr_data == KEY_CFG_A)      state_d = KS_CFG_HALF;
                    else if (wr_data == KEY_RST_A) state_d = KS_RST_HALF;
                    else                           state_d = KS_IDLE;
                end
                KS_CFG_HALF: state_d = (wr_data == KEY_CFG_B) ? KS_CFG_OPEN : KS_IDLE;
                KS_CFG_OPEN: state_d = KS_IDLE;
                KS_RST_HALF: state_d = KS_IDLE;
                default:     state_d = KS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        load_ctrl = 1'b0;
        restart   = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                KS_CFG_OPEN: load_ctrl = 1'b1;
                KS_RST_HALF: restart   = (wr_data == KEY_RST_B);
                default: begin
                    load_ctrl = 1'b0;
                    restart   = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/wdt_period_counter.sv
module wdt_period_counter #(
    parameter int BASE_EXP = 24,
    parameter int SEL_W    = 7,
    localparam int CNT_W   = BASE_EXP + SEL_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             armed,
    input  logic [SEL_W-1:0] sel,
    output logic             expire,
    output logic             pulse_q,
    output logic [CNT_W-1:0] cnt_q
);

    logic [CNT_W-1:0] limit;

    // terminal count for the lowest set select bit
    always_comb begin
        int idx;
        idx = 0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel[i]) idx = i;
        end
        limit = '0;
        for (int j = 0; j < CNT_W; j++) begin
            if (j < BASE_EXP + idx) limit[j] = 1'b1;
        end
    end

    assign expire = armed && !clear && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire;
            if (clear || expire) cnt_q <= '0;
            else if (armed)      cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 24,
    localparam int CNT_W   = BASE_EXP + SEL_W - 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] ctrl_q,
    output logic        expired_flag,
    output logic        timeout_pulse
);

    key_state_e       st;
    logic             ld_ctrl;
    logic             do_restart;
    logic             armed;
    logic             expire;
    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] sel;

    wdt_key_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .state_q   (st),
        .load_ctrl (ld_ctrl),
        .restart   (do_restart)
    );

    assign sel   = ctrl_q[SEL_LSB +: SEL_W];
    assign armed = ctrl_q[ARM_HI_BIT] && ctrl_q[ARM_LO_BIT] && (|sel);

    wdt_period_counter #(
        .BASE_EXP (BASE_EXP),
        .SEL_W    (SEL_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ld_ctrl || do_restart),
        .armed   (armed),
        .sel     (sel),
        .expire  (expire),
        .pulse_q (timeout_pulse),
        .cnt_q   (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            expired_flag <= 1'b0;
        end else begin
            if (ld_ctrl) ctrl_q <= wr_data;
            if (do_restart)  expired_flag <= 1'b0;
            else if (expire) expired_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_data,
    input logic [15:0]      ctrl_q,
    input logic             expired_flag,
    input logic             timeout_pulse,
    input key_state_e       st,
    input logic             do_restart,
    input logic [CNT_W-1:0] cnt
);

    assert_pulse_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (ctrl_q[15] && ctrl_q[14] && (|ctrl_q[7:1])));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> expired_flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(expired_flag) |-> $past(do_restart));

    assert_ctrl_guard_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> ($past(wr_en) && $past(st) == KS_CFG_OPEN));

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_restart |=> (cnt == '0 && !timeout_pulse));

    assert_broken_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == KS_CFG_HALF && wr_data != KEY_CFG_B) |=> st == KS_IDLE);

endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .ctrl_q        (ctrl_q),
    .expired_flag  (expired_flag),
    .timeout_pulse (timeout_pulse),
    .st            (st),
    .do_restart    (do_restart),
    .cnt           (cnt)
);

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;

    localparam int BE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_q;
    logic        expired_flag;
    logic        timeout_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdt_keyed #(.BASE_EXP(BE)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .ctrl_q        (ctrl_q),
        .expired_flag  (expired_flag),
        .timeout_pulse (timeout_pulse)
    );

    // behavioural reference: 0 idle, 1 cfg half, 2 cfg open, 3 restart half
    int          m_state = 0;
    logic [15:0] m_ctrl = '0;
    longint      m_cnt = 0;
    bit          m_pulse = 0;
    bit          m_flag = 0;

    function automatic longint period_of(logic [15:0] c);
        for (int k = 1; k <= 7; k++) if (c[k]) return longint'(1) << (BE + k - 1);
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_ctrl = '0; m_cnt = 0; m_pulse = 0; m_flag = 0;
        end else begin
            bit ld, rs, arm;
            longint p;
            ld = 0; rs = 0;
            p = period_of(m_ctrl);
            arm = m_ctrl[15] && m_ctrl[14] && (p != 0);
            if (wr_en) begin
                case (m_state)
                    0: m_state = (wr_data == 16'h3333) ? 1 : (wr_data == 16'hAAAA) ? 3 : 0;
                    1: m_state = (wr_data == 16'hCCCC) ? 2 : 0;
                    2: begin ld = 1; m_state = 0; end
                    default: begin rs = (wr_data == 16'h5555); m_state = 0; end
                endcase
            end
            m_pulse = 0;
            if (ld || rs) m_cnt = 0;
            else if (arm) begin
                if (m_cnt == p - 1) begin m_cnt = 0; m_pulse = 1; end
                else m_cnt++;
            end
            if (rs) m_flag = 0;
            else if (m_pulse) m_flag = 1;
            if (ld) m_ctrl = wr_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (ctrl_q !== m_ctrl) begin
                n_fail++; $display("FAIL R1 ctrl_q actual %h expected %h", ctrl_q, m_ctrl);
            end
            n_chk++;
            if (timeout_pulse !== m_pulse) begin
                n_fail++; $display("FAIL R6 timeout_pulse actual %b expected %b", timeout_pulse, m_pulse);
            end
            n_chk++;
            if (expired_flag !== m_flag) begin
                n_fail++; $display("FAIL R8 expired_flag actual %b expected %b", expired_flag, m_flag);
            end
        end
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(logic [15:0] v);
        wr(16'h3333); wr(16'hCCCC); wr(v);
    endtask

    task automatic kick();
        wr(16'hAAAA); wr(16'h5555);
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!timeout_pulse && n < 5000);
    endtask

    task automatic quiet(int cycles, string req);
        int seen = 0;
        repeat (cycles) begin @(negedge clk); if (timeout_pulse) seen++; end
        check(req, seen, 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 ctrl", ctrl_q, 0);
        check("R11 flag", expired_flag, 0);
        check("R11 pulse", timeout_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cfg(16'hC002);
        check("R1 load", ctrl_q, 16'hC002);
        measure(n); check("R5 period bit1", n, 16);
        check("R8 flag set", expired_flag, 1);
        @(negedge clk); check("R6 one cycle", timeout_pulse, 0);
        measure(n); check("R6 repeat period", n, 16 - 1);

        cfg(16'hC004);
        check("R8 load keeps flag", expired_flag, 1);
        measure(n); check("R5 period bit2", n, 32);

        kick();
        check("R8 restart clears flag", expired_flag, 0);
        check("R3 ctrl unchanged", ctrl_q, 16'hC004);

        // R9 frequent restarts
        for (int r = 0; r < 6; r++) begin
            quiet(18, "R9 no pulse");
            kick();
        end

        cfg(16'hC080);
        measure(n); check("R5 period bit7", n, 1024);

        // R7 broken sequences
        wr(16'h3333); wr(16'h1234); wr(16'hCCCC); wr(16'h0000);
        check("R7 cfg key broken", ctrl_q, 16'hC080);
        wr(16'hAAAA); wr(16'h0000); wr(16'h5555);
        check("R7 restart key broken", expired_flag, 1);

        // R4 arm condition
        cfg(16'h4002); quiet(100, "R4 bit15 clear");
        cfg(16'h8002); quiet(100, "R4 bit14 clear");
        cfg(16'hC000); quiet(100, "R4 no select bit");

        // R5 lowest set bit selects
        cfg(16'hC006);
        measure(n); check("R5 lowest bit wins", n, 16);

        // R10 restart on expiry edge
        kick();
        cfg(16'hC002);
        repeat (14) @(negedge clk);
        wr(16'hAAAA); wr(16'h5555);
        check("R10 no pulse", timeout_pulse, 0);
        check("R10 no flag", expired_flag, 0);
        measure(n); check("R10 full period after", n, 16);

        // R2 disable
        cfg(16'h0000);
        check("R2 ctrl zero", ctrl_q, 0);
        quiet(200, "R2 disarmed");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule